// File: doc/BRIEF.md
# Column-Interleaved Pixel Defect Concealment

This block sits between the converter array of an image sensor and the rest of the image pipeline. The sensor's columns are shared out over `NCONV` converters so that column `c` is always converted by converter `c % NCONV`. Pixels therefore reach the block grouped by converter rather than in raster order. Each input pixel carries the tag of the converter that produced it. The block places every pixel of a row at its natural column, then sends the row out left to right.

On the way out, any pixel that came from a converter marked bad in `defect_mask` is replaced by a value built from its same-colour neighbours. With a two-colour row pattern those neighbours are the raw pixels two columns to the left and two columns to the right. Rows never mix: interleaving acts on columns only, so the row order of the stream is unchanged.

The block holds two row banks, so one row can be loaded while the previous one drains. Both streams use valid/ready. A transfer happens on a clock edge where valid and ready are both high. `in_ready` falls while both banks hold complete rows. When `out_valid` is high and `out_ready` is low, the output word is held unchanged.

Top module: `cic_defect_conceal`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Within a row, the k-th pixel accepted with tag t (k counted from 0 for that tag) lands in column k*NCONV + t. Converters may be interleaved in any order, as long as each converter's own pixels arrive left to right. Columns whose converter is not flagged come out exactly as received.
- R3: A flagged pixel at column c, where both c-2 and c+2 lie inside the row, is output as (p[c-2] + p[c+2] + 1) >> 1. The sum is formed one bit wider than a pixel, so the result never wraps.
- R4: A flagged pixel in column 0 or 1 is output as p[c+2]. A flagged pixel in either of the last two columns is output as p[c-2].
- R5: `defect_mask` bit t flags converter t. The mask is captured on the first accepted pixel of each row and applies to that whole row. Mask changes after that pixel do not affect the row.
- R6: `out_valid` stays 0 until a full row of ROW_W pixels has been accepted. When both banks are empty, the first pixel of the row is presented one cycle after the edge that accepts the row's last input pixel.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` keep their values.
- R8: `out_last` is 1 exactly on column ROW_W-1 of each output row.
- R9: Two complete rows can be held. While both banks are full, `in_ready` is 0. Rows leave in the order they arrived.
- R10: Neighbour values are always the raw received pixels, even when a neighbour is itself flagged. Several flagged converters are therefore each handled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can accept an input pixel |
| in_data | input | PIX_W | Input pixel value |
| in_tag | input | TAG_W | Converter that produced the pixel |
| defect_mask | input | NCONV | One flag per converter, 1 = bad |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | PIX_W | Corrected pixel, raster order |
| out_last | output | 1 | Marks the last column of a row |

## Verification
The bench builds the block with PIX_W=8, ROW_W=12 and NCONV=3. With eight-bit pixels, full-scale neighbours such as 255 and 254 test whether the rounded average can wrap. With three converters, every converter owns an edge column, and flagging two adjacent converters makes one flagged pixel the neighbour of another. The twelve-column row is short enough to fill both banks and check the blocked input, and each converter-order pattern still places four pixels per converter.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Natural column of the slot-th pixel produced by converter tag.
  function automatic int natural_col(int slot, int tag, int nconv);
    return slot * nconv + tag;
  endfunction
  // Smallest row that still has one interior same-colour triple.
  localparam int MIN_ROW_W = 5;
endpackage

// File: rtl/cic_deinterleave.sv
module cic_deinterleave #(
  parameter int ROW_W = 12,
  parameter int NCONV = 3,
  localparam int COL_W = $clog2(ROW_W),
  localparam int TAG_W = $clog2(NCONV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [TAG_W-1:0] tag,
  output logic [COL_W-1:0] wr_col,
  output logic             wr_first,
  output logic             wr_done
);
  localparam int CPC = ROW_W / NCONV;

  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] slot_q [NCONV];
  logic [TAG_W-1:0] tag_idx;

  assign tag_idx  = (int'(tag) < NCONV) ? tag : '0;
  assign wr_col   = COL_W'(cic_pkg::natural_col(int'(slot_q[tag_idx]), int'(tag_idx), NCONV));
  assign wr_first = (cnt_q == '0);
  assign wr_done  = (cnt_q == COL_W'(ROW_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (fire && wr_done) cnt_q <= '0;
    else if (fire)            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NCONV; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                    slot_q[g] <= '0;
      else if (fire && wr_done)                      slot_q[g] <= '0;
      else if (fire && tag_idx == TAG_W'(g))         slot_q[g] <= slot_q[g] + 1'b1;
    end
  end

  AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (int'(tag) < NCONV) && (int'(slot_q[tag_idx]) < CPC)); // R2
endmodule

// File: rtl/cic_conceal.sv
module cic_conceal #(
  parameter int PIX_W = 8,
  parameter int ROW_W = 12,
  parameter int NCONV = 3,
  localparam int COL_W = $clog2(ROW_W)
) (
  input  logic [ROW_W*PIX_W-1:0] row_flat,
  input  logic [NCONV-1:0]       mask,
  input  logic [COL_W-1:0]       col,
  output logic [PIX_W-1:0]       pix
);
  int             ci, li, ri;
  logic           has_l, has_r, bad;
  logic [PIX_W-1:0] raw, lft, rgt, avg;
  logic [PIX_W:0]   sum;

  always_comb begin
    ci    = int'(col);
    has_l = (ci >= 2);
    has_r = (ci + 2 < ROW_W);
    li    = has_l ? ci - 2 : ci;
    ri    = has_r ? ci + 2 : ci;
    raw   = row_flat[ci*PIX_W +: PIX_W];
    lft   = row_flat[li*PIX_W +: PIX_W];
    rgt   = row_flat[ri*PIX_W +: PIX_W];
    bad   = mask[ci % NCONV];
    sum   = {1'b0, lft} + {1'b0, rgt} + (PIX_W+1)'(1);
    avg   = PIX_W'(sum >> 1);
    if (!bad)                pix = raw;
    else if (has_l && has_r) pix = avg;
    else if (has_l)          pix = lft;
    else                     pix = rgt;
  end

  always_comb begin
    if (bad && has_l && has_r)
      AST_AVG_BETWEEN: assert ((pix >= lft || pix >= rgt) && (pix <= lft || pix <= rgt)); // R3
  end
endmodule

// File: rtl/cic_defect_conceal.sv
module cic_defect_conceal #(
  parameter int PIX_W = 8,
  parameter int ROW_W = 12,
  parameter int NCONV = 3,
  localparam int COL_W = $clog2(ROW_W),
  localparam int TAG_W = $clog2(NCONV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [NCONV-1:0] defect_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_last
);
  localparam int NBANK = 2;

  logic [ROW_W*PIX_W-1:0] bank_q [NBANK];
  logic [NBANK*NCONV-1:0] mask_q;
  logic [NBANK-1:0]       full_q;
  logic                   wsel_q, rsel_q;
  logic [COL_W-1:0]       rd_col_q, wr_col;
  logic                   wr_first, wr_done, fire, out_fire, rd_end;

  assign in_ready  = !full_q[wsel_q];
  assign fire      = in_valid && in_ready;
  assign out_valid = full_q[rsel_q];
  assign out_fire  = out_valid && out_ready;
  assign rd_end    = (rd_col_q == COL_W'(ROW_W - 1));
  assign out_last  = out_valid && rd_end;

  cic_deinterleave #(.ROW_W(ROW_W), .NCONV(NCONV)) i_deint (
    .clk(clk), .rst_n(rst_n), .fire(fire), .tag(in_tag),
    .wr_col(wr_col), .wr_first(wr_first), .wr_done(wr_done));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (fire && wsel_q == 1'(b))
        bank_q[b][int'(wr_col)*PIX_W +: PIX_W] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      full_q   <= '0;
      wsel_q   <= 1'b0;
      rsel_q   <= 1'b0;
      rd_col_q <= '0;
    end else begin
      if (fire && wr_first) mask_q[int'(wsel_q)*NCONV +: NCONV] <= defect_mask;
      if (fire && wr_done) begin
        full_q[wsel_q] <= 1'b1;
        wsel_q         <= ~wsel_q;
      end
      if (out_fire) begin
        if (rd_end) begin
          rd_col_q       <= '0;
          full_q[rsel_q] <= 1'b0;
          rsel_q         <= ~rsel_q;
        end else begin
          rd_col_q <= rd_col_q + 1'b1;
        end
      end
    end
  end

  cic_conceal #(.PIX_W(PIX_W), .ROW_W(ROW_W), .NCONV(NCONV)) i_conceal (
    .row_flat(bank_q[rsel_q]),
    .mask(mask_q[int'(rsel_q)*NCONV +: NCONV]),
    .col(rd_col_q),
    .pix(out_data));

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7
  AST_MASK_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && wr_first) |=> $stable(mask_q)); // R5
  AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (rd_col_q == '0)); // R8
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fire && wr_done)); // R6
endmodule

// File: tb/test_cic_defect_conceal.sv
`timescale 1ns/1ps
module test_cic_defect_conceal;
  localparam int PIX_W = 8;
  localparam int ROW_W = 12;
  localparam int NCONV = 3;
  localparam int CPC   = ROW_W / NCONV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [PIX_W-1:0] in_data = '0;
  logic [1:0] in_tag = '0;
  logic [NCONV-1:0] defect_mask = '0;
  logic in_ready, out_valid, out_last;
  logic [PIX_W-1:0] out_data;

  int checks = 0, errors = 0;
  int pix [ROW_W];
  int pix2 [ROW_W];

  always #2.5 clk = ~clk;

  cic_defect_conceal #(.PIX_W(PIX_W), .ROW_W(ROW_W), .NCONV(NCONV)) i_cic_defect_conceal (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tag(in_tag), .defect_mask(defect_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int p[ROW_W], input int c, input logic [NCONV-1:0] m);
    if (!m[c % NCONV]) return p[c];
    if (c >= 2 && c + 2 < ROW_W) return (p[c-2] + p[c+2] + 1) / 2;
    if (c < 2) return p[c+2];
    return p[c-2];
  endfunction

  task automatic fill(output int p[ROW_W], input int seed);
    for (int c = 0; c < ROW_W; c++) p[c] = (seed * 37 + c * 53 + c * c * 7) % 256;
  endtask

  task automatic push(input int v, input int t);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = PIX_W'(v); in_tag = 2'(t);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // order 0: converter-major, 1: round-robin, 2: converter-major reversed
  task automatic push_row(input int p[ROW_W], input int order);
    for (int i = 0; i < ROW_W; i++) begin
      int k, s, c;
      if (order == 1) begin s = i / NCONV; k = i % NCONV; end
      else begin k = i / CPC; s = i % CPC; if (order == 2) k = NCONV - 1 - k; end
      c = s * NCONV + k;
      push(p[c], k);
    end
  endtask

  task automatic pop(output int v, output int l);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    v = int'(out_data); l = int'(out_last);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pop_row(input int p[ROW_W], input logic [NCONV-1:0] m, input string req);
    for (int c = 0; c < ROW_W; c++) begin
      int v, l;
      pop(v, l);
      check($sformatf("%s col %0d", req, c), v, model(p, c, m));
      check($sformatf("R8 last col %0d", c), l, (c == ROW_W - 1) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_orders();
    for (int o = 0; o < 3; o++) begin
      fill(pix, o + 1);
      defect_mask = '0;
      push_row(pix, o);
      pop_row(pix, '0, "R2 order");
    end
  endtask

  task automatic t_conceal_each();
    for (int k = 0; k < NCONV; k++) begin
      fill(pix, k + 7);
      defect_mask = NCONV'(1 << k);
      push_row(pix, 0);
      pop_row(pix, NCONV'(1 << k), "R3/R4 single");
    end
  endtask

  task automatic t_round_full_scale();
    for (int c = 0; c < ROW_W; c++) pix[c] = (c % 2 == 0) ? 255 : 254;
    pix[5] = 0; pix[3] = 255; pix[7] = 254;
    defect_mask = 3'b100;
    push_row(pix, 1);
    pop_row(pix, 3'b100, "R3 round");
  endtask

  task automatic t_mask_midrow();
    fill(pix, 21);
    defect_mask = '0;
    push(pix[0], 0);
    defect_mask = 3'b010;
    for (int i = 1; i < ROW_W; i++) push(pix[i], i % NCONV);
    pop_row(pix, '0, "R5 midrow");
    fill(pix, 22);
    push_row(pix, 1);
    pop_row(pix, 3'b010, "R5 next row");
  endtask

  task automatic t_fill_latency();
    fill(pix, 31);
    defect_mask = '0;
    for (int i = 0; i < ROW_W - 1; i++) push(pix[i], i % NCONV);
    check("R6 valid before last", int'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = PIX_W'(pix[ROW_W-1]); in_tag = 2'((ROW_W - 1) % NCONV);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 valid after last", int'(out_valid), 1);
    pop_row(pix, '0, "R6 data");
  endtask

  task automatic t_backpressure();
    int v0, l0;
    fill(pix, 41);
    defect_mask = 3'b001;
    push_row(pix, 0);
    @(negedge clk);
    v0 = int'(out_data); l0 = int'(out_last);
    repeat (4) @(negedge clk);
    check("R7 valid held", int'(out_valid), 1);
    check("R7 data held", int'(out_data), v0);
    check("R7 last held", int'(out_last), l0);
    pop_row(pix, 3'b001, "R7 data");
  endtask

  task automatic t_two_rows();
    fill(pix, 51); fill(pix2, 52);
    defect_mask = 3'b001;
    push_row(pix, 0);
    defect_mask = 3'b100;
    push_row(pix2, 2);
    @(negedge clk);
    check("R9 in_ready blocked", int'(in_ready), 0);
    pop_row(pix, 3'b001, "R9 first row");
    pop_row(pix2, 3'b100, "R9 second row");
    check("R9 in_ready free", int'(in_ready), 1);
  endtask

  task automatic t_multi_bad();
    fill(pix, 61);
    defect_mask = 3'b011;
    push_row(pix, 1);
    pop_row(pix, 3'b011, "R10 multi");
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_orders();
    t_conceal_each();
    t_round_full_scale();
    t_mask_midrow();
    t_fill_latency();
    t_backpressure();
    t_two_rows();
    t_multi_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule